// File: doc/BRIEF.md
# Part-Number String Decoder

This block turns a part identifier kept in non-volatile memory into ASCII text. On a start pulse it fetches two header words over a simple word-read port. It compares the first header word with a guard constant to decide how the identifier is stored. The characters leave on a byte stream with a last flag, at most one per clock. A one-cycle done pulse then carries a two-bit status code.

In the packed form, the two header words hold hexadecimal digits. These are expanded into a fixed eleven-character string with a dash in it. In the indirect form, the second header word points at a length word, and the string bytes follow that length word in memory. Before any character is sent, the block compares the string size against a capacity given on an input. An invalid length, a capacity that is too small, or a failed memory read ends the run with an error code.

Top module: `pnd_decoder`

## Requirements
- R1: After reset `busy`, `rd_req`, `out_valid`, `out_last` and `done` are all low.
- R2: A run reads word `HDR0_ADDR` first and then word `HDR1_ADDR`. A pending read keeps `rd_req` high and `rd_addr` unchanged until `rd_ack`.
- R3: When header word 0 is not equal to `GUARD`, the output is 11 characters in this order: the four nibbles of word 0 from the most significant nibble down, then bits 15:12 and 11:8 of word 1, then '-' (0x2D), then '0' (0x30), then bits 7:4 and 3:0 of word 1, then 0x00.
- R4: Each packed nibble value 0-9 becomes 0x30-0x39 and each value 10-15 becomes 0x41-0x46 (uppercase A-F).
- R5: In packed form, a `capacity` below 11 ends the run with status 1 (no space) and no characters. A capacity of exactly 11 succeeds.
- R6: When header word 0 equals `GUARD`, the block reads the length word L at the address held in header word 1. It then reads words L-1 at the following addresses in rising order and sends each one as its high byte and then its low byte, followed by 0x00. L = 1 gives the 0x00 alone.
- R7: A length word of 0x0000 or 0xFFFF ends the run with status 2 (bad section) and no characters.
- R8: In indirect form, a `capacity` below 2*L-1 ends the run with status 1 and no characters. A capacity of exactly 2*L-1 succeeds.
- R9: A read answered with `rd_err` high ends the run with status 3 (read error). No character is sent after that read.
- R10: `done` is high for exactly one cycle per run. On success (status 0) it comes in the same cycle as the final 0x00 character, which carries `out_last`.
- R11: A `start` pulse while `busy` is high has no effect: there is no second run and no second `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a decode; taken only when idle |
| capacity | input | CAP_W | Character capacity of the consumer, captured at start |
| busy | output | 1 | A run is in progress |
| rd_req | output | 1 | Word read request, held until acknowledged |
| rd_addr | output | AW | Word address of the pending read |
| rd_ack | input | 1 | Read completed this cycle |
| rd_data | input | 16 | Read data, valid with `rd_ack` |
| rd_err | input | 1 | Read failed, valid with `rd_ack` |
| out_valid | output | 1 | A character is present on `out_char` |
| out_char | output | 8 | ASCII character |
| out_last | output | 1 | This character is the terminating 0x00 |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | Result: 0 ok, 1 no space, 2 bad section, 3 read error; valid with `done` |

## Verification
The hardest case to reach is a read error in the middle of an indirect string. By then some characters have already gone out, and the error must stop the stream cleanly with no terminator. The bench's memory model can fail the read at one chosen address. It points the error at the second data word of a three-word string, so exactly two characters should appear before status 3. A second hard case is a `start` pulse during a run. The bench raises `start` a few cycles after launch, then waits well past the end of the run and checks that no second `done` or character appears.

// File: rtl/pnd_pkg.sv
package pnd_pkg;

  typedef enum logic [1:0] {
    ST_OK          = 2'd0,
    ST_NO_SPACE    = 2'd1,
    ST_BAD_SECTION = 2'd2,
    ST_READ_ERR    = 2'd3
  } pnd_status_e;

  localparam int PACKED_CHARS = 11;
  localparam int PACKED_LAST  = PACKED_CHARS - 1;

  localparam logic [7:0] CH_DASH = 8'h2D;
  localparam logic [7:0] CH_NUL  = 8'h00;

  // nibble to uppercase hex text
  function automatic logic [7:0] nib_ascii(input logic [3:0] n);
    logic [7:0] r;
    if (n < 4'd10) r = 8'h30 + {4'd0, n};
    else           r = 8'h37 + {4'd0, n};
    return r;
  endfunction

  function automatic logic is_hex_ascii(input logic [7:0] c);
    return ((c >= 8'h30) && (c <= 8'h39)) || ((c >= 8'h41) && (c <= 8'h46));
  endfunction

  // characters needed by an indirect string of length word len
  function automatic logic [17:0] indirect_need(input logic [15:0] len);
    return {1'b0, len, 1'b0} - 18'd1;
  endfunction

endpackage

// File: rtl/pnd_nvm_port.sv
module pnd_nvm_port #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [15:0]   rd_data,
  input  logic          rd_err,
  output logic          got,
  output logic [15:0]   got_data,
  output logic          got_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_req  <= 1'b0;
      rd_addr <= '0;
    end else if (issue) begin
      rd_req  <= 1'b1;
      rd_addr <= issue_addr;
    end else if (rd_req && rd_ack) begin
      rd_req  <= 1'b0;
    end
  end

  assign got      = rd_req & rd_ack;
  assign got_data = rd_data;
  assign got_err  = rd_err;

  a_r2_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

endmodule

// File: rtl/pnd_packed_char.sv
module pnd_packed_char
  import pnd_pkg::*;
(
  input  logic [15:0] hw0,
  input  logic [15:0] hw1,
  input  logic [3:0]  idx,
  output logic [7:0]  ch
);

  always_comb begin
    unique case (idx)
      4'd0:    ch = nib_ascii(hw0[15:12]);
      4'd1:    ch = nib_ascii(hw0[11:8]);
      4'd2:    ch = nib_ascii(hw0[7:4]);
      4'd3:    ch = nib_ascii(hw0[3:0]);
      4'd4:    ch = nib_ascii(hw1[15:12]);
      4'd5:    ch = nib_ascii(hw1[11:8]);
      4'd6:    ch = CH_DASH;
      4'd7:    ch = nib_ascii(4'd0);
      4'd8:    ch = nib_ascii(hw1[7:4]);
      4'd9:    ch = nib_ascii(hw1[3:0]);
      default: ch = CH_NUL;
    endcase
  end

endmodule

// File: rtl/pnd_room_check.sv
module pnd_room_check
  import pnd_pkg::*;
#(
  parameter int CAP_W = 16
) (
  input  logic [CAP_W-1:0] cap,
  input  logic [15:0]      len,
  output logic             packed_short,
  output logic             len_bad,
  output logic             indirect_short
);

  assign packed_short   = cap < CAP_W'(PACKED_CHARS);
  assign len_bad        = (len == 16'h0000) || (len == 16'hFFFF);
  assign indirect_short = indirect_need(len) > 18'(cap);

endmodule

// File: rtl/pnd_decoder.sv
module pnd_decoder
  import pnd_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          CAP_W     = 16,
  parameter logic [15:0] GUARD     = 16'hFAFA,
  parameter logic [15:0] HDR0_ADDR = 16'h0015,
  parameter logic [15:0] HDR1_ADDR = 16'h0016
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CAP_W-1:0] capacity,
  output logic             busy,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_ack,
  input  logic [15:0]      rd_data,
  input  logic             rd_err,
  output logic             out_valid,
  output logic [7:0]       out_char,
  output logic             out_last,
  output logic             done,
  output logic [1:0]       status
);

  typedef enum logic [3:0] {
    S_IDLE, S_HDR0, S_HDR1, S_LEN, S_WORD, S_HI, S_LO, S_PACK, S_NUL
  } state_e;

  state_e           state_q;
  logic [15:0]      hw0_q, hw1_q, word_q, left_q;
  logic [AW-1:0]    ptr_q;
  logic [CAP_W-1:0] cap_q;
  logic [3:0]       idx_q;
  logic             packed_q;

  logic             issue;
  logic [AW-1:0]    issue_addr;
  logic             got, got_err;
  logic [15:0]      got_data;
  logic             packed_short, len_bad, indirect_short;
  logic [7:0]       pack_ch;

  // named events for checking
  logic             hdr_is_packed;
  logic             run_fail;

  pnd_nvm_port #(.AW(AW)) u_port (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_addr(issue_addr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_err(rd_err), .got(got), .got_data(got_data), .got_err(got_err)
  );

  pnd_room_check #(.CAP_W(CAP_W)) u_room (
    .cap(cap_q), .len(got_data), .packed_short(packed_short),
    .len_bad(len_bad), .indirect_short(indirect_short)
  );

  pnd_packed_char u_pack (
    .hw0(hw0_q), .hw1(hw1_q), .idx(idx_q), .ch(pack_ch)
  );

  assign busy          = (state_q != S_IDLE);
  assign hdr_is_packed = (hw0_q != GUARD);
  assign run_fail      = got && got_err;

  // read issue decisions
  always_comb begin
    issue      = 1'b0;
    issue_addr = '0;
    unique case (state_q)
      S_IDLE: if (start) begin
        issue      = 1'b1;
        issue_addr = AW'(HDR0_ADDR);
      end
      S_HDR0: if (got && !got_err) begin
        issue      = 1'b1;
        issue_addr = AW'(HDR1_ADDR);
      end
      S_HDR1: if (got && !got_err && (hw0_q == GUARD)) begin
        issue      = 1'b1;
        issue_addr = got_data[AW-1:0];
      end
      S_LEN: if (got && !got_err && !len_bad && !indirect_short &&
                 (got_data != 16'd1)) begin
        issue      = 1'b1;
        issue_addr = hw1_q[AW-1:0] + AW'(1);
      end
      S_LO: if (left_q != 16'd1) begin
        issue      = 1'b1;
        issue_addr = ptr_q + AW'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      hw0_q     <= '0;
      hw1_q     <= '0;
      word_q    <= '0;
      left_q    <= '0;
      ptr_q     <= '0;
      cap_q     <= '0;
      idx_q     <= '0;
      packed_q  <= 1'b0;
      out_valid <= 1'b0;
      out_char  <= '0;
      out_last  <= 1'b0;
      done      <= 1'b0;
      status    <= ST_OK;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      done      <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start) begin
          cap_q    <= capacity;
          packed_q <= 1'b0;
          state_q  <= S_HDR0;
        end
        S_HDR0: if (got) begin
          if (got_err) begin
            done <= 1'b1; status <= ST_READ_ERR; state_q <= S_IDLE;
          end else begin
            hw0_q   <= got_data;
            state_q <= S_HDR1;
          end
        end
        S_HDR1: if (got) begin
          hw1_q <= got_data;
          if (got_err) begin
            done <= 1'b1; status <= ST_READ_ERR; state_q <= S_IDLE;
          end else if (hdr_is_packed) begin
            if (packed_short) begin
              done <= 1'b1; status <= ST_NO_SPACE; state_q <= S_IDLE;
            end else begin
              packed_q <= 1'b1;
              idx_q    <= '0;
              state_q  <= S_PACK;
            end
          end else begin
            state_q <= S_LEN;
          end
        end
        S_LEN: if (got) begin
          if (got_err) begin
            done <= 1'b1; status <= ST_READ_ERR; state_q <= S_IDLE;
          end else if (len_bad) begin
            done <= 1'b1; status <= ST_BAD_SECTION; state_q <= S_IDLE;
          end else if (indirect_short) begin
            done <= 1'b1; status <= ST_NO_SPACE; state_q <= S_IDLE;
          end else begin
            left_q  <= got_data - 16'd1;
            ptr_q   <= hw1_q[AW-1:0] + AW'(1);
            state_q <= (got_data == 16'd1) ? S_NUL : S_WORD;
          end
        end
        S_WORD: if (got) begin
          if (got_err) begin
            done <= 1'b1; status <= ST_READ_ERR; state_q <= S_IDLE;
          end else begin
            word_q  <= got_data;
            state_q <= S_HI;
          end
        end
        S_HI: begin
          out_valid <= 1'b1;
          out_char  <= word_q[15:8];
          state_q   <= S_LO;
        end
        S_LO: begin
          out_valid <= 1'b1;
          out_char  <= word_q[7:0];
          left_q    <= left_q - 16'd1;
          ptr_q     <= ptr_q + AW'(1);
          state_q   <= (left_q == 16'd1) ? S_NUL : S_WORD;
        end
        S_NUL: begin
          out_valid <= 1'b1;
          out_char  <= CH_NUL;
          out_last  <= 1'b1;
          done      <= 1'b1;
          status    <= ST_OK;
          state_q   <= S_IDLE;
        end
        S_PACK: begin
          out_valid <= 1'b1;
          out_char  <= pack_ch;
          idx_q     <= idx_q + 4'd1;
          if (idx_q == 4'(PACKED_LAST)) begin
            out_last <= 1'b1;
            done     <= 1'b1;
            status   <= ST_OK;
            state_q  <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(issue) |-> !rd_req);

  a_r10_last_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> done && (status == ST_OK));

  a_r10_ok_done_has_last: assert property (@(posedge clk) disable iff (!rst_n)
    done && (status == ST_OK) |-> out_valid && out_last);

  a_r9_error_silent: assert property (@(posedge clk) disable iff (!rst_n)
    run_fail |=> !out_valid && done && (status == ST_READ_ERR));

  a_r4_packed_text: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && packed_q && !out_last |-> is_hex_ascii(out_char) || (out_char == CH_DASH));

  a_r11_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/pnd_decoder_test.sv
module pnd_decoder_test;

  localparam logic [15:0] GUARD = 16'hFAFA;
  localparam logic [15:0] H0    = 16'h0015;
  localparam logic [15:0] H1    = 16'h0016;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] capacity = '0;
  logic        busy, rd_req, out_valid, out_last, done;
  logic [15:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic [15:0] rd_data = '0;
  logic        rd_err = 1'b0;
  logic [7:0]  out_char;
  logic [1:0]  status;

  always #10 clk = ~clk;

  pnd_decoder #(.GUARD(GUARD), .HDR0_ADDR(H0), .HDR1_ADDR(H1)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .capacity(capacity), .busy(busy),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_err(rd_err), .out_valid(out_valid), .out_char(out_char),
    .out_last(out_last), .done(done), .status(status)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] mem [0:255];
  bit          err_en = 1'b0;
  logic [15:0] err_addr = '0;

  logic [15:0] alog [0:63];
  int          alog_n = 0;
  logic [7:0]  gotb [0:63];
  int          got_n = 0;
  int          done_n = 0;
  logic [1:0]  st_seen = '0;
  int          last_n = 0;

  logic [7:0]  expb [0:63];
  int          exp_n = 0;

  // memory responder: one-cycle gap between acknowledges
  always @(negedge clk) begin
    if (rd_ack) begin
      rd_ack = 1'b0;
      rd_err = 1'b0;
    end else if (rd_req) begin
      rd_ack  = 1'b1;
      rd_data = mem[rd_addr[7:0]];
      rd_err  = err_en && (rd_addr == err_addr);
      if (alog_n < 64) alog[alog_n] = rd_addr;
      alog_n++;
    end
  end

  // output collector
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (got_n < 64) gotb[got_n] = out_char;
      got_n++;
      if (out_last) last_n++;
    end
    if (rst_n && done) begin
      done_n++;
      st_seen = status;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] n);
    string digits = "0123456789ABCDEF";
    return digits[n];
  endfunction

  task automatic push(input logic [7:0] b);
    expb[exp_n] = b;
    exp_n++;
  endtask

  task automatic expect_packed(input logic [15:0] a, input logic [15:0] b);
    exp_n = 0;
    push(hexc(a[15:12])); push(hexc(a[11:8])); push(hexc(a[7:4])); push(hexc(a[3:0]));
    push(hexc(b[15:12])); push(hexc(b[11:8]));
    push("-"); push("0");
    push(hexc(b[7:4])); push(hexc(b[3:0]));
    push(8'h00);
  endtask

  task automatic expect_indirect(input logic [15:0] p, input int upto);
    logic [15:0] len;
    exp_n = 0;
    len = mem[p[7:0]];
    for (int i = 1; i < int'(len) && i <= upto; i++) begin
      push(mem[8'(p + 16'(i))][15:8]);
      push(mem[8'(p + 16'(i))][7:0]);
    end
    if (upto >= int'(len)) push(8'h00);
  endtask

  task automatic run(input logic [15:0] cap, input logic [1:0] exp_st,
                     input string rq, input bit poke);
    got_n = 0; done_n = 0; alog_n = 0; last_n = 0;
    @(negedge clk);
    capacity = cap;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3000 && done_n == 0; i++) begin
      @(negedge clk);
      start = poke && (i == 2);
    end
    start = 1'b0;
    repeat (25) @(negedge clk);
    chk(done_n == 1, rq, "done count", done_n, 1);
    chk(st_seen == exp_st, rq, "status", st_seen, exp_st);
    chk(got_n == exp_n, rq, "char count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk(gotb[i] == expb[i], rq, $sformatf("char %0d", i), gotb[i], expb[i]);
    chk(last_n == ((exp_st == 2'd0) ? 1 : 0), rq, "last flags", last_n,
        (exp_st == 2'd0) ? 1 : 0);
  endtask

  task automatic t_reset;
    chk(!busy && !rd_req && !out_valid && !out_last && !done, "R1", "reset outputs",
        {busy, rd_req, out_valid, out_last, done}, 0);
  endtask

  task automatic t_packed_a;
    mem[H0] = 16'h3F9C; mem[H1] = 16'hE05D;
    expect_packed(16'h3F9C, 16'hE05D);
    run(16'd40, 2'd0, "R3", 1'b0);
    chk(alog_n == 2 && alog[0] == H0 && alog[1] == H1, "R2", "header order",
        {alog[0], alog[1]}, {H0, H1});
  endtask

  task automatic t_packed_b;
    mem[H0] = 16'h0000; mem[H1] = 16'hABF9;
    expect_packed(16'h0000, 16'hABF9);
    run(16'd11, 2'd0, "R4", 1'b0);
  endtask

  task automatic t_packed_short;
    mem[H0] = 16'h1234; mem[H1] = 16'h5678;
    exp_n = 0;
    run(16'd10, 2'd1, "R5", 1'b0);
  endtask

  task automatic t_indirect;
    mem[H0] = GUARD; mem[H1] = 16'h0040;
    mem[8'h40] = 16'd3; mem[8'h41] = 16'h4142; mem[8'h42] = 16'h4344;
    expect_indirect(16'h0040, 99);
    run(16'd5, 2'd0, "R6", 1'b0);
    chk(alog_n == 5 && alog[2] == 16'h0040 && alog[3] == 16'h0041 && alog[4] == 16'h0042,
        "R6", "address walk", alog[4], 16'h0042);
  endtask

  task automatic t_indirect_one;
    mem[H0] = GUARD; mem[H1] = 16'h0050;
    mem[8'h50] = 16'd1;
    expect_indirect(16'h0050, 99);
    run(16'd1, 2'd0, "R6", 1'b0);
  endtask

  task automatic t_indirect_short;
    mem[H0] = GUARD; mem[H1] = 16'h0040;
    mem[8'h40] = 16'd3;
    exp_n = 0;
    run(16'd4, 2'd1, "R8", 1'b0);
    mem[8'h40] = 16'd4; mem[8'h43] = 16'h7A30;
    expect_indirect(16'h0040, 99);
    run(16'd7, 2'd0, "R8", 1'b0);
  endtask

  task automatic t_bad_len;
    mem[H0] = GUARD; mem[H1] = 16'h0060;
    mem[8'h60] = 16'h0000;
    exp_n = 0;
    run(16'd200, 2'd2, "R7", 1'b0);
    mem[8'h60] = 16'hFFFF;
    run(16'd200, 2'd2, "R7", 1'b0);
  endtask

  task automatic t_read_err;
    mem[H0] = GUARD; mem[H1] = 16'h0040;
    mem[8'h40] = 16'd3; mem[8'h41] = 16'h4142; mem[8'h42] = 16'h4344;
    err_en = 1'b1; err_addr = 16'h0042;
    expect_indirect(16'h0040, 1);
    run(16'd50, 2'd3, "R9", 1'b0);
    err_addr = H1;
    exp_n = 0;
    run(16'd50, 2'd3, "R9", 1'b0);
    err_en = 1'b0;
  endtask

  task automatic t_busy_start;
    mem[H0] = 16'h0BAD; mem[H1] = 16'hC0DE;
    expect_packed(16'h0BAD, 16'hC0DE);
    run(16'd11, 2'd0, "R11", 1'b1);
    chk(alog_n == 2, "R11", "reads after extra start", alog_n, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_packed_a();
    t_packed_b();
    t_packed_short();
    t_indirect();
    t_indirect_one();
    t_indirect_short();
    t_bad_len();
    t_read_err();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule